// File: doc/BRIEF.md
# Two-Agent Hardware Semaphore Bank

This block keeps a bank of byte-wide semaphore registers shared by two requesters. Each requester has its own access port and issues one access per cycle: a read or a write, aimed at an entry index, with a size code. A read of a free entry returns zero and, in the same access, hands the entry to the reader. A read of a held entry only reports the current owner. A write can only give up the writer's own hold. Software on either side takes a lock by reading until it sees zero, and frees the lock by writing zero.

Each entry is a small state machine with three states. FREE is stored as 00. HELD0 is stored as 01 and means requester 0 owns the entry. HELD1 is stored as 10 and means requester 1 owns it. The named transitions are: acquire0 (FREE to HELD0), acquire1 (FREE to HELD1), release0 (HELD0 to FREE), release1 (HELD1 to FREE), and handoff (the owner releases while the other requester reads in the same cycle, so the entry goes straight to the reader). Responses come back one cycle after the request on a per-port response bus.

Top module: `sema_bank`

## Requirements
- R1: After a synchronous reset every entry is FREE, so the first read of any entry returns 0x00.
- R2: A one-byte read of a FREE entry returns 0x00 and moves the entry to the reader's state. Requester 0 owns bit 0 (value 0x01) and requester 1 owns bit 1 (value 0x02).
- R3: A one-byte read of a held entry returns the stored value (0x01 or 0x02) and leaves the entry unchanged, whichever requester reads.
- R4: A one-byte write with the writer's own bit (bit p for port p) at 0 frees the entry only if the writer holds it. A write never clears the other requester's bit.
- R5: A write with the writer's own bit at 1 changes nothing, and never acquires a FREE entry.
- R6: An access whose size code is not 00 (00 = one byte; 01, 10 and 11 = two, four and eight bytes) updates no entry, returns 0x00, and raises the error flag in its response.
- R7: When both requesters read the same FREE entry in one cycle, requester 0 gets 0x00 and the entry becomes 0x01, and requester 1 gets 0x01.
- R8: When a release and a read of the same entry meet in one cycle, the release takes effect first and the read sees the freed entry. Accesses to different entries do not interact.
- R9: Each access gets exactly one response, flagged valid on the cycle after the request. A write response carries data 0x00 and no error.
- R10: Read data bits 7:2 are always zero, and no entry ever holds both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 2 | Per-port request valid (bit p = port p) |
| req_wr | input | 2 | Per-port 1 = write, 0 = read |
| req_size | input | 4 | Per-port size code, 2 bits each, 00 = one byte |
| req_idx | input | 18 | Per-port entry index, 9 bits each |
| req_wdata | input | 16 | Per-port write byte, 8 bits each |
| rsp_vld | output | 2 | Per-port response valid |
| rsp_rdata | output | 16 | Per-port read byte, 8 bits each |
| rsp_err | output | 2 | Per-port error flag for a multi-byte access |

## Verification
The assertions assume that each port carries at most one access per cycle, that reset is held for at least one edge before the first request, and that the index and size inputs are stable while the request is valid. They make no assumption about how the two ports relate, because colliding and identical accesses are the cases that matter. The stimulus drives inputs only on the falling edge, keeps most random indexes to a handful of entries so that reads, releases and collisions hit the same entry often, and mixes in multi-byte size codes, write-one bytes and accesses to the last index.

// File: rtl/sema_pkg.sv
package sema_pkg;

    localparam int NREQ = 2;
    localparam int DW   = 8;
    localparam int SW   = 2;

    typedef enum logic [1:0] {
        ST_FREE  = 2'b00,
        ST_HELD0 = 2'b01,
        ST_HELD1 = 2'b10
    } sema_st_e;

    function automatic logic [DW-1:0] st_to_byte(input sema_st_e s);
        return {{(DW-2){1'b0}}, s};
    endfunction

endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec
    import sema_pkg::*;
#(
    parameter int PORT = 0,
    parameter int IDXW = 9
) (
    input  logic            vld,
    input  logic            wr,
    input  logic [SW-1:0]   size,
    input  logic [DW-1:0]   wdata,
    output logic            one_byte,
    output logic            rd_en,
    output logic            rel_en,
    output logic            bad
);

    always_comb begin
        one_byte = (size == '0);
        rd_en    = vld && !wr && one_byte;
        // only the writer's own bit matters; every other bit is dropped
        rel_en   = vld && wr && one_byte && !wdata[PORT];
        bad      = vld && !one_byte;
    end

endmodule

// File: rtl/sema_entry.sv
module sema_entry
    import sema_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   rd,
    input  logic [NREQ-1:0]   rel,
    output logic [1:0]        view0,
    output logic [1:0]        view1
);

    sema_st_e st, mid, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_FREE;
        else     st <= nxt;
    end

    always_comb begin
        mid = st;
        unique case (st)
            ST_FREE:  mid = ST_FREE;
            ST_HELD0: if (rel[0]) mid = ST_FREE;
            ST_HELD1: if (rel[1]) mid = ST_FREE;
            default:  mid = ST_FREE;
        endcase
        nxt = mid;
        if (mid == ST_FREE) begin
            if (rd[0])      nxt = ST_HELD0;
            else if (rd[1]) nxt = ST_HELD1;
        end
    end

    always_comb begin
        view0 = mid;
        view1 = (mid == ST_FREE && rd[0]) ? ST_HELD0 : mid;
    end

    AST_NO_BOTH_SET: assert property (@(posedge clk) disable iff (rst)
        st != 2'b11); // R10
    AST_HOLD0_KEEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HELD0 && !rel[0]) |=> st == ST_HELD0); // R3
    AST_HOLD1_KEEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HELD1 && !rel[1]) |=> st == ST_HELD1); // R4
    AST_FREE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FREE && rd == '0) |=> st == ST_FREE); // R5
    AST_TIE_TO_REQ0: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FREE && rd == 2'b11) |=> st == ST_HELD0); // R7

endmodule

// File: rtl/sema_rsp.sv
module sema_rsp
    import sema_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            vld,
    input  logic            rd_en,
    input  logic            bad,
    input  logic [1:0]      view,
    output logic            o_vld,
    output logic [DW-1:0]   o_rdata,
    output logic            o_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld   <= 1'b0;
            o_rdata <= '0;
            o_err   <= 1'b0;
        end else begin
            o_vld   <= vld;
            o_err   <= bad;
            o_rdata <= rd_en ? st_to_byte(sema_st_e'(view)) : '0;
        end
    end

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        o_err |-> (o_rdata == '0 && o_vld)); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        o_rdata[DW-1:2] == '0); // R10
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        vld |=> o_vld); // R9

endmodule

// File: rtl/sema_bank.sv
module sema_bank
    import sema_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      req_vld,
    input  logic [NREQ-1:0]      req_wr,
    input  logic [NREQ*SW-1:0]   req_size,
    input  logic [NREQ*IDXW-1:0] req_idx,
    input  logic [NREQ*DW-1:0]   req_wdata,
    output logic [NREQ-1:0]      rsp_vld,
    output logic [NREQ*DW-1:0]   rsp_rdata,
    output logic [NREQ-1:0]      rsp_err
);

    logic [NREQ-1:0] rd_en, rel_en, bad, one_byte;
    logic [IDXW-1:0] idx [NREQ];
    logic [1:0]      view0 [DEPTH];
    logic [1:0]      view1 [DEPTH];
    logic [1:0]      sel   [NREQ];

    for (genvar p = 0; p < NREQ; p++) begin : g_port
        assign idx[p] = req_idx[p*IDXW +: IDXW];

        sema_port_dec #(.PORT(p), .IDXW(IDXW)) u_dec (
            .vld      (req_vld[p]),
            .wr       (req_wr[p]),
            .size     (req_size[p*SW +: SW]),
            .wdata    (req_wdata[p*DW +: DW]),
            .one_byte (one_byte[p]),
            .rd_en    (rd_en[p]),
            .rel_en   (rel_en[p]),
            .bad      (bad[p])
        );
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [NREQ-1:0] hit_rd, hit_rel;
        for (genvar p = 0; p < NREQ; p++) begin : g_hit
            assign hit_rd[p]  = rd_en[p]  && (idx[p] == IDXW'(e));
            assign hit_rel[p] = rel_en[p] && (idx[p] == IDXW'(e));
        end
        sema_entry u_ent (
            .clk   (clk),
            .rst   (rst),
            .rd    (hit_rd),
            .rel   (hit_rel),
            .view0 (view0[e]),
            .view1 (view1[e])
        );
    end

    assign sel[0] = view0[idx[0]];
    assign sel[1] = view1[idx[1]];

    for (genvar p = 0; p < NREQ; p++) begin : g_rsp
        sema_rsp u_rsp (
            .clk     (clk),
            .rst     (rst),
            .vld     (req_vld[p]),
            .rd_en   (rd_en[p]),
            .bad     (bad[p]),
            .view    (sel[p]),
            .o_vld   (rsp_vld[p]),
            .o_rdata (rsp_rdata[p*DW +: DW]),
            .o_err   (rsp_err[p])
        );
    end

    AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_vld[0] && req_wr[0] && one_byte[0]) |=> (!rsp_err[0] && rsp_rdata[DW-1:0] == '0)); // R9
    AST_MULTI_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (req_vld[1] && req_size[2*SW-1:SW] != '0) |=> rsp_err[1]); // R6
    AST_NOT_BOTH_WIN: assert property (@(posedge clk) disable iff (rst)
        (rd_en == 2'b11 && idx[0] == idx[1]) |=> rsp_rdata[2*DW-1:DW] != 8'h00); // R7

endmodule

// File: tb/sim_sema_bank.sv
module sim_sema_bank;

    localparam int DEPTH = 512;
    localparam int IW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_vld = '0, req_wr = '0;
    logic [3:0]  req_size = '0;
    logic [17:0] req_idx = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  rsp_vld, rsp_err;
    logic [15:0] rsp_rdata;

    always #2 clk = ~clk;

    sema_bank u0 (.*);

    int checks = 0, failures = 0;
    logic [1:0] model [DEPTH];
    logic [7:0] e_rd [2];
    logic       e_err [2];
    logic       e_vld [2];
    string      e_tag [2];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive both ports on the falling edge, predict, then check one cycle later
    task automatic cyc(input logic v0, w0, input logic [1:0] s0, input int i0, input logic [7:0] d0,
                       input logic v1, w1, input logic [1:0] s1, input int i1, input logic [7:0] d1);
        logic v[2], w[2]; logic [1:0] s[2]; int i[2]; logic [7:0] d[2];
        v[0]=v0; w[0]=w0; s[0]=s0; i[0]=i0; d[0]=d0;
        v[1]=v1; w[1]=w1; s[1]=s1; i[1]=i1; d[1]=d1;
        req_vld   = {v1, v0};
        req_wr    = {w1, w0};
        req_size  = {s1, s0};
        req_idx   = {IW'(i1), IW'(i0)};
        req_wdata = {d1, d0};
        for (int p = 0; p < 2; p++) begin
            e_vld[p] = v[p]; e_rd[p] = 8'h00; e_err[p] = v[p] && s[p] != 0;
            e_tag[p] = e_err[p] ? "R6" : (w[p] ? "R9" : "R3");
        end
        // releases first (R8), own bit only (R4), write-1 ignored (R5)
        for (int p = 0; p < 2; p++)
            if (v[p] && w[p] && s[p] == 0 && !d[p][p]) model[i[p]][p] = 1'b0;
        // reads in priority order (R7)
        for (int p = 0; p < 2; p++)
            if (v[p] && !w[p] && s[p] == 0) begin
                e_rd[p] = {6'b0, model[i[p]]};
                if (model[i[p]] == 2'b00) begin
                    model[i[p]][p] = 1'b1;
                    e_tag[p] = "R2";
                end
            end
        @(posedge clk);
        @(negedge clk);
        req_vld = '0;
        for (int p = 0; p < 2; p++) begin
            chk("R9", {31'b0, rsp_vld[p]}, {31'b0, e_vld[p]});
            if (e_vld[p]) begin
                chk(e_tag[p], {24'b0, rsp_rdata[p*8 +: 8]}, {24'b0, e_rd[p]});
                chk("R6", {31'b0, rsp_err[p]}, {31'b0, e_err[p]});
            end
            chk("R10", {30'b0, model[i[p]]} == 32'd3 ? 32'd1 : 32'd0, 32'd0);
        end
    endtask

    task automatic rd0(input int i); cyc(1,0,0,i,0, 0,0,0,0,0); endtask
    task automatic rd1(input int i); cyc(0,0,0,0,0, 1,0,0,i,0); endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) model[k] = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9", {30'b0, rsp_vld}, 0);
        // R1: fresh entries read as zero
        rd0(0); rd1(511); rd0(300);
        // R3: held entries report owner, any reader
        rd1(0); rd0(0); rd0(511);
        // R4: other side cannot free; owner can
        cyc(0,0,0,0,0, 1,1,0,0,8'h00); rd1(0);
        cyc(1,1,0,0,8'hFE, 0,0,0,0,0); rd1(0);
        // R5: write-1 on own bit, on a free entry, does not acquire
        cyc(1,1,0,7,8'hFF, 1,1,0,8,8'hFF); rd1(7); rd0(8);
        // R6: multi-byte read of free entry: error, no acquire
        cyc(1,0,2'b01,20,0, 1,0,2'b11,21,0); rd1(20); rd0(21);
        cyc(1,1,2'b10,20,8'h00, 0,0,0,0,0); rd1(20);
        // R7: tie on a free entry
        cyc(1,0,0,30,0, 1,0,0,30,0);
        // R8: owner 0 releases while 1 reads: handoff
        cyc(1,1,0,30,8'h00, 1,0,0,30,0); rd0(30);
        // R8: different entries in parallel
        cyc(1,0,0,40,0, 1,0,0,41,0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic v0, v1, w0, w1; logic [1:0] s0, s1; int i0, i1;
            v0 = ($urandom % 4) != 0; v1 = ($urandom % 4) != 0;
            w0 = $urandom % 2; w1 = $urandom % 2;
            s0 = ($urandom % 8 == 0) ? 2'($urandom % 3 + 1) : 2'b00;
            s1 = ($urandom % 8 == 0) ? 2'($urandom % 3 + 1) : 2'b00;
            i0 = ($urandom % 16 == 0) ? 511 : int'($urandom % 6);
            i1 = ($urandom % 16 == 0) ? 511 : int'($urandom % 6);
            cyc(v0, w0, s0, i0, 8'($urandom), v1, w1, s1, i1, 8'($urandom));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial void'($urandom(32'd12345));

endmodule